// File: doc/BRIEF.md
# Six-Step Commutation Gate Driver

This block turns a brushless-motor commutation step into six gate signals, one high-side and one low-side switch for each of phases U, V and W. A zero-cross strobe marks each back-EMF event. The block measures the clock cycles between two strobes, which is one 60° electrical step. It then waits a fraction of that interval before it advances the step. The wait is 30° less the selected lead angle. PWM chopping is applied to the conducting high-side switch. The conducting low-side switch stays fully on.

In forced (startup) mode the lead is held at zero whatever the lead select says. Once the mode input reports natural commutation, the selected lead of 7.5° or 15° takes effect. An optional overlap mode keeps the outgoing switch conducting together with the incoming one for a window set by the lead. The high-side output polarity can be chosen. A speed output toggles on each natural commutation, which gives three pulses per electrical revolution. It is held low in startup mode and while the block is disabled. A low enable is how a fault or a stop is signalled to the block.

Top module: `sixstep_gate_drive`

## Requirements
- R1: Each step turns on one high-side and one low-side switch: step 0 U-high/V-low, 1 U-high/W-low, 2 V-high/W-low, 3 V-high/U-low, 4 W-high/U-low, 5 W-high/V-low. When `dir_rev`=0 the step rises by one (5 wraps to 0) on each commutation, so the high side runs U→V→W. Enable low puts the step back to 0.
- R2: When `dir_rev`=1 the step falls by one (0 wraps to 5) on each commutation, so the high side runs U→W→V.
- R3: In natural mode (`nat_mode`=1) with a measured strobe interval of P cycles, the step changes floor(P/4)+floor(P/8) cycles after the strobe clock edge when `lead_hi`=0 (7.5° lead), and floor(P/4) cycles after it when `lead_hi`=1 (15° lead).
- R4: In forced mode (`nat_mode`=0) the delay is floor(P/2) cycles (zero lead), whatever the value of `lead_hi`.
- R5: With `ovl_en`=1, after each commutation the outgoing switch stays on together with the incoming one for floor(P/8) cycles in natural mode with 7.5° lead, floor(P/4) cycles in natural mode with 15° lead, and 0 cycles in forced mode. The high and low switch of one phase are never on at the same time.
- R6: With `ovl_en`=0, exactly one high-side and one low-side switch conduct while enabled (120° conduction).
- R7: The high-side switch that conducts follows `pwm_in`. The low-side switch that conducts stays on when `pwm_in` is low.
- R8: Low-side outputs are active high. High-side outputs are active low when `hs_act_hi`=0 and active high when `hs_act_hi`=1.
- R9: While `en`=0, every gate output sits at its inactive level and `speed_fg` is low one cycle later.
- R10: `speed_fg` toggles on each commutation in natural mode. It is cleared, and stays low, in forced mode.
- R11: If a strobe arrives on the same clock edge at which a pending delay expires, the commutation still takes place on that edge, and a new delay is scheduled from the interval that has just been measured.
- R12: The first strobe after reset or after enable only starts the interval measurement. It causes no commutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Drive enable; low means stop or fault |
| zc_stb | input | 1 | One-cycle back-EMF zero-cross strobe |
| pwm_in | input | 1 | PWM chopping signal |
| dir_rev | input | 1 | 0 forward, 1 reverse sequence |
| lead_hi | input | 1 | 0 for 7.5° lead, 1 for 15° lead (natural mode) |
| ovl_en | input | 1 | Overlap commutation enable |
| hs_act_hi | input | 1 | 0 high side active low, 1 high side active high |
| nat_mode | input | 1 | 0 forced startup, 1 natural commutation |
| gate_uh | output | 1 | Phase U high-side gate |
| gate_ul | output | 1 | Phase U low-side gate |
| gate_vh | output | 1 | Phase V high-side gate |
| gate_vl | output | 1 | Phase V low-side gate |
| gate_wh | output | 1 | Phase W high-side gate |
| gate_wl | output | 1 | Phase W low-side gate |
| speed_fg | output | 1 | Speed pulse output |

## Verification
A new zero-cross strobe and the expiry of the previous commutation delay can fall on the same clock edge. The bench provokes this in forced mode: it times a third strobe exactly half an interval after the second. It then checks that the step advances on that very edge, and that the next advance comes at half of the new, shorter interval, not the old one. A commutation and the start of an overlap window also fall on the same edge. The bench checks that window by sampling the two low-side outputs on the first and on the last cycle of the window.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

   localparam int unsigned NUM_PHASES = 3;
   localparam int unsigned NUM_STEPS  = 6;

   typedef enum logic [1:0] {
      LEAD_ZERO = 2'd0,
      LEAD_LOW  = 2'd1,
      LEAD_HIGH = 2'd2
   } lead_e;

   // bit 0 = U, bit 1 = V, bit 2 = W
   typedef struct packed {
      logic [NUM_PHASES-1:0] hs;
      logic [NUM_PHASES-1:0] ls;
   } phase_on_t;

   function automatic phase_on_t step_decode(input logic [2:0] s);
      phase_on_t r;
      case (s)
         3'd0:    begin r.hs = 3'b001; r.ls = 3'b010; end
         3'd1:    begin r.hs = 3'b001; r.ls = 3'b100; end
         3'd2:    begin r.hs = 3'b010; r.ls = 3'b100; end
         3'd3:    begin r.hs = 3'b010; r.ls = 3'b001; end
         3'd4:    begin r.hs = 3'b100; r.ls = 3'b001; end
         3'd5:    begin r.hs = 3'b100; r.ls = 3'b010; end
         default: begin r.hs = 3'b000; r.ls = 3'b000; end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sixstep_lead_timer.sv
module sixstep_lead_timer
   import sixstep_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             zc_stb,
   input  logic             nat_mode,
   input  logic             lead_hi,
   output logic             comm,
   output logic [CNT_W-1:0] ovl_len
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] per_cnt;
   logic [CNT_W-1:0] dly_cnt;
   logic [CNT_W-1:0] dly_calc;
   logic [CNT_W-1:0] dly_raw;
   logic [CNT_W-1:0] win_calc;
   logic             have_ref;
   lead_e            lead_sel;

   // lead is zero until natural commutation is reported
   always_comb begin
      if (!nat_mode)    lead_sel = LEAD_ZERO;
      else if (lead_hi) lead_sel = LEAD_HIGH;
      else              lead_sel = LEAD_LOW;
   end

   // 30 deg = P/2, 22.5 deg = 3P/8, 15 deg = P/4; overlap = lead share of P
   always_comb begin
      case (lead_sel)
         LEAD_LOW: begin
            dly_raw  = (per_cnt >> 2) + (per_cnt >> 3);
            win_calc = per_cnt >> 3;
         end
         LEAD_HIGH: begin
            dly_raw  = per_cnt >> 2;
            win_calc = per_cnt >> 2;
         end
         default: begin
            dly_raw  = per_cnt >> 1;
            win_calc = '0;
         end
      endcase
      dly_calc = (dly_raw == '0) ? CNT_ONE : dly_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_cnt  <= '0;
         have_ref <= 1'b0;
         dly_cnt  <= '0;
         ovl_len  <= '0;
      end else if (!en) begin
         per_cnt  <= '0;
         have_ref <= 1'b0;
         dly_cnt  <= '0;
         ovl_len  <= '0;
      end else begin
         if (zc_stb)                  per_cnt <= CNT_ONE;
         else if (per_cnt != CNT_MAX) per_cnt <= per_cnt + CNT_ONE;

         if (zc_stb) have_ref <= 1'b1;

         if (zc_stb && have_ref) begin
            dly_cnt <= dly_calc;
            ovl_len <= win_calc;
         end else if (dly_cnt != '0) begin
            dly_cnt <= dly_cnt - CNT_ONE;
         end
      end
   end

   assign comm = (dly_cnt == CNT_ONE);

   assert_dly_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !zc_stb && dly_cnt != '0) |=> (dly_cnt == $past(dly_cnt) - CNT_ONE));

   assert_first_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !have_ref) |-> (dly_cnt == '0));

endmodule

// File: rtl/sixstep_sequencer.sv
module sixstep_sequencer
   import sixstep_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             comm,
   input  logic             dir_rev,
   input  logic             ovl_en,
   input  logic             nat_mode,
   input  logic [CNT_W-1:0] ovl_len,
   output logic [2:0]       step_q,
   output logic [2:0]       prev_q,
   output logic             ovl_act,
   output logic             fg_q
);

   localparam logic [2:0] LAST_STEP = 3'(NUM_STEPS - 1);

   logic [CNT_W-1:0] ovl_cnt;
   logic [2:0]       step_nxt;

   always_comb begin
      if (dir_rev) step_nxt = (step_q == 3'd0) ? LAST_STEP : step_q - 3'd1;
      else         step_nxt = (step_q == LAST_STEP) ? 3'd0 : step_q + 3'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= '0;
         prev_q  <= '0;
         ovl_cnt <= '0;
      end else if (!en) begin
         step_q  <= '0;
         prev_q  <= '0;
         ovl_cnt <= '0;
      end else if (comm) begin
         prev_q  <= step_q;
         step_q  <= step_nxt;
         ovl_cnt <= ovl_en ? ovl_len : '0;
      end else if (ovl_cnt != '0) begin
         ovl_cnt <= ovl_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                fg_q <= 1'b0;
      else if (!en || !nat_mode) fg_q <= 1'b0;
      else if (comm)             fg_q <= ~fg_q;
   end

   assign ovl_act = (ovl_cnt != '0);

   assert_step_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= LAST_STEP);

   assert_step_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !comm) |=> $stable(step_q));

   assert_fg_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!nat_mode) |=> !fg_q);

endmodule

// File: rtl/sixstep_gate_map.sv
module sixstep_gate_map
   import sixstep_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [2:0]            step_q,
   input  logic [2:0]            prev_q,
   input  logic                  ovl_act,
   input  logic                  pwm_in,
   input  logic                  hs_act_hi,
   output logic [NUM_PHASES-1:0] gate_h,
   output logic [NUM_PHASES-1:0] gate_l
);

   phase_on_t             cur_on;
   phase_on_t             old_on;
   logic [NUM_PHASES-1:0] hs_on;
   logic [NUM_PHASES-1:0] ls_on;

   always_comb begin
      cur_on = step_decode(step_q);
      old_on = step_decode(prev_q);
      hs_on  = cur_on.hs | (ovl_act ? old_on.hs : '0);
      ls_on  = cur_on.ls | (ovl_act ? old_on.ls : '0);
   end

   for (genvar ph = 0; ph < NUM_PHASES; ph++) begin : g_phase
      logic hs_drive;
      assign hs_drive   = en & hs_on[ph] & pwm_in;
      assign gate_h[ph] = hs_act_hi ? hs_drive : ~hs_drive;
      assign gate_l[ph] = en & ls_on[ph];

      assert_no_shoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !(hs_on[ph] && ls_on[ph]));
   end

   assert_one_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ovl_act) |-> ($countones(hs_on) == 1 && $countones(ls_on) == 1));

endmodule

// File: rtl/sixstep_gate_drive.sv
module sixstep_gate_drive
   import sixstep_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic zc_stb,
   input  logic pwm_in,
   input  logic dir_rev,
   input  logic lead_hi,
   input  logic ovl_en,
   input  logic hs_act_hi,
   input  logic nat_mode,
   output logic gate_uh,
   output logic gate_ul,
   output logic gate_vh,
   output logic gate_vl,
   output logic gate_wh,
   output logic gate_wl,
   output logic speed_fg
);

   initial begin
      assert_cnt_width: assert (CNT_W >= 4 && CNT_W <= 32)
         else $error("CNT_W out of range");
   end

   logic                  comm;
   logic [CNT_W-1:0]      ovl_len;
   logic [2:0]            step_q;
   logic [2:0]            prev_q;
   logic                  ovl_act;
   logic [NUM_PHASES-1:0] gate_h;
   logic [NUM_PHASES-1:0] gate_l;

   sixstep_lead_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .zc_stb   (zc_stb),
      .nat_mode (nat_mode),
      .lead_hi  (lead_hi),
      .comm     (comm),
      .ovl_len  (ovl_len)
   );

   sixstep_sequencer #(.CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .comm     (comm),
      .dir_rev  (dir_rev),
      .ovl_en   (ovl_en),
      .nat_mode (nat_mode),
      .ovl_len  (ovl_len),
      .step_q   (step_q),
      .prev_q   (prev_q),
      .ovl_act  (ovl_act),
      .fg_q     (speed_fg)
   );

   sixstep_gate_map u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .step_q    (step_q),
      .prev_q    (prev_q),
      .ovl_act   (ovl_act),
      .pwm_in    (pwm_in),
      .hs_act_hi (hs_act_hi),
      .gate_h    (gate_h),
      .gate_l    (gate_l)
   );

   assign gate_uh = gate_h[0];
   assign gate_vh = gate_h[1];
   assign gate_wh = gate_h[2];
   assign gate_ul = gate_l[0];
   assign gate_vl = gate_l[1];
   assign gate_wl = gate_l[2];

   assert_idle_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |-> ({gate_ul, gate_vl, gate_wl} == 3'b000 &&
                 {gate_uh, gate_vh, gate_wh} == {3{~hs_act_hi}}));

   assert_idle_fg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> !speed_fg);

endmodule

// File: tb/test_sixstep_gate_drive.sv
`timescale 1ns/1ps
module test_sixstep_gate_drive;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, zc = 1'b0, pwm = 1'b1;
   logic dir_rev = 1'b0, lead_hi = 1'b0, ovl_en = 1'b0, hs_act_hi = 1'b0, nat = 1'b1;
   logic uh, ul, vh, vl, wh, wl, fg;
   logic [5:0] gates;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sixstep_gate_drive i_sixstep_gate_drive (
      .clk(clk), .rst_n(rst_n), .en(en), .zc_stb(zc), .pwm_in(pwm),
      .dir_rev(dir_rev), .lead_hi(lead_hi), .ovl_en(ovl_en),
      .hs_act_hi(hs_act_hi), .nat_mode(nat),
      .gate_uh(uh), .gate_ul(ul), .gate_vh(vh), .gate_vl(vl),
      .gate_wh(wh), .gate_wl(wl), .speed_fg(fg)
   );

   assign gates = {uh, ul, vh, vl, wh, wl};

   // vector: {nat, lead_hi, period[9:0], delay[9:0]}, delays from R3/R4
   localparam int NVEC = 7;
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 10'd64, 10'd24},
      {1'b1, 1'b1, 10'd64, 10'd16},
      {1'b0, 1'b0, 10'd64, 10'd32},
      {1'b0, 1'b1, 10'd64, 10'd32},
      {1'b1, 1'b0, 10'd40, 10'd15},
      {1'b1, 1'b1, 10'd40, 10'd10},
      {1'b0, 1'b1, 10'd40, 10'd20}
   };

   // R1 step table; bit order of the result is {uh,ul,vh,vl,wh,wl}
   function automatic logic [5:0] expect_gates(input int s, input logic p,
                                               input logic pol, input logic e);
      logic [2:0] h, l, hv;
      case (s)
         0: begin h = 3'b001; l = 3'b010; end
         1: begin h = 3'b001; l = 3'b100; end
         2: begin h = 3'b010; l = 3'b100; end
         3: begin h = 3'b010; l = 3'b001; end
         4: begin h = 3'b100; l = 3'b001; end
         default: begin h = 3'b100; l = 3'b010; end
      endcase
      if (!e) begin h = 3'b000; l = 3'b000; end
      h  = h & {3{p}};
      hv = pol ? h : ~h;
      return {hv[0], l[0], hv[1], l[1], hv[2], l[2]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse();
      zc = 1'b1;
      @(negedge clk);
      zc = 1'b0;
   endtask

   task automatic restart();
      en = 1'b0;
      repeat (2) @(negedge clk);
      en = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(input int p, output int d);
      logic [5:0] old;
      pulse();
      wait_n(p - 1);
      old = gates;
      pulse();
      d = 0;
      while (gates == old && d < 2000) begin
         @(negedge clk);
         d++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int d;
      logic [5:0] e;
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: disabled after reset
      e = expect_gates(0, 1'b1, 1'b0, 1'b0);
      check(gates == e, "R9", "reset idle gates", gates, e);
      check(fg == 1'b0, "R9", "reset speed", fg, 0);
      en = 1'b1;
      @(negedge clk);
      e = expect_gates(0, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R1", "step 0 after enable", gates, e);

      // R3 / R4 delay vectors
      for (int i = 0; i < NVEC; i++) begin
         nat     = VEC[i][21];
         lead_hi = VEC[i][20];
         restart();
         measure(int'(VEC[i][19:10]), d);
         check(d == int'(VEC[i][9:0]), VEC[i][21] ? "R3" : "R4", "commutation delay",
               d, int'(VEC[i][9:0]));
      end

      // R1 / R10 forward run, natural mode, 15 deg lead, P=64 -> D=16
      nat = 1'b1; lead_hi = 1'b1; ovl_en = 1'b0;
      restart();
      pulse();
      wait_n(63);
      for (int i = 0; i < 6; i++) begin
         pulse();
         wait_n(16);
         e = expect_gates((i + 1) % 6, 1'b1, 1'b0, 1'b1);
         check(gates == e, "R1", "forward step", gates, e);
         check(fg == 1'((i + 1) % 2), "R10", "speed toggle", fg, (i + 1) % 2);
         wait_n(47);
      end

      // R7 chopping on high side only
      pwm = 1'b0;
      @(negedge clk);
      e = expect_gates(0, 1'b0, 1'b0, 1'b1);
      check(gates == e, "R7", "pwm low", gates, e);
      // R8 polarity
      hs_act_hi = 1'b1;
      @(negedge clk);
      e = expect_gates(0, 1'b0, 1'b1, 1'b1);
      check(gates == e, "R8", "active-high pwm low", gates, e);
      pwm = 1'b1;
      @(negedge clk);
      e = expect_gates(0, 1'b1, 1'b1, 1'b1);
      check(gates == e, "R8", "active-high pwm high", gates, e);
      hs_act_hi = 1'b0;
      @(negedge clk);
      e = expect_gates(0, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R8", "active-low pwm high", gates, e);

      // R2 reverse
      dir_rev = 1'b1;
      restart();
      pulse();
      wait_n(63);
      pulse();
      wait_n(16);
      e = expect_gates(5, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R2", "reverse first step", gates, e);
      wait_n(47);
      pulse();
      wait_n(16);
      e = expect_gates(4, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R2", "reverse second step", gates, e);
      dir_rev = 1'b0;

      // R9 disable mid-run
      en = 1'b0;
      @(negedge clk);
      e = expect_gates(0, 1'b1, 1'b0, 1'b0);
      check(gates == e, "R9", "disabled gates", gates, e);
      check(fg == 1'b0, "R9", "disabled speed", fg, 0);
      en = 1'b1;
      @(negedge clk);
      e = expect_gates(0, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R9", "step back to 0", gates, e);

      // R10 forced mode keeps speed low, R4 delay 32
      nat = 1'b0;
      restart();
      pulse();
      wait_n(63);
      pulse();
      wait_n(32);
      e = expect_gates(1, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R4", "forced commutation", gates, e);
      check(fg == 1'b0, "R10", "forced speed low", fg, 0);

      // R11 strobe on the expiry edge
      restart();
      pulse();
      wait_n(63);
      pulse();
      wait_n(31);
      pulse();
      e = expect_gates(1, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R11", "commutation on coincident edge", gates, e);
      wait_n(15);
      check(gates == e, "R11", "hold before new delay", gates, e);
      @(negedge clk);
      e = expect_gates(2, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R11", "new delay from new period", gates, e);

      // R5 overlap, 7.5 deg lead: D=24, window 8
      nat = 1'b1; lead_hi = 1'b0; ovl_en = 1'b1;
      restart();
      pulse();
      wait_n(63);
      pulse();
      wait_n(24);
      e = expect_gates(1, 1'b1, 1'b0, 1'b1) | 6'b000100;
      check(gates == e, "R5", "overlap start 7.5", gates, e);
      wait_n(7);
      check(gates == e, "R5", "overlap end 7.5", gates, e);
      @(negedge clk);
      e = expect_gates(1, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R5", "after overlap 7.5", gates, e);

      // R5 overlap, 15 deg lead: D=16, window 16
      lead_hi = 1'b1;
      restart();
      pulse();
      wait_n(63);
      pulse();
      wait_n(16);
      e = expect_gates(1, 1'b1, 1'b0, 1'b1) | 6'b000100;
      check(gates == e, "R5", "overlap start 15", gates, e);
      wait_n(15);
      check(gates == e, "R5", "overlap end 15", gates, e);
      @(negedge clk);
      e = expect_gates(1, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R5", "after overlap 15", gates, e);

      // R5 forced mode: no overlap window
      nat = 1'b0;
      restart();
      pulse();
      wait_n(63);
      pulse();
      wait_n(32);
      e = expect_gates(1, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R5", "no overlap in forced mode", gates, e);
      ovl_en = 1'b0;

      // R6: one high and one low conducting with overlap off
      check($countones({~uh, ~vh, ~wh}) == 1 && $countones({ul, vl, wl}) == 1,
            "R6", "one pair", gates, e);

      // R12 single strobe does nothing
      nat = 1'b1;
      restart();
      pulse();
      wait_n(200);
      e = expect_gates(0, 1'b1, 1'b0, 1'b1);
      check(gates == e, "R12", "first strobe no commutation", gates, e);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule